// File: doc/BRIEF.md
# Zero-Turnaround Flow-Through Synchronous SRAM

This block is a synthesizable model of a synchronous burst SRAM. Read data appears in the same cycle as its registered address, so reads are flow-through. Reads and writes can follow each other in any order at one transfer per clock with no idle cycle. This works because the data of a write trails its address and control by one enabled clock.

Every control, address and byte-select input is registered on the rising clock edge. A clock enable freezes the whole block. A load/advance input either starts a new access or steps a 2-bit burst counter. The counter runs in linear or interleaved order.

A write whose data has been captured sits in a one-entry pending buffer until the next enabled edge. Reads of that address see the buffered bytes merged over the array contents. Three chip enables and a sleep input gate access. An asynchronous output-enable gates the data-out drivers, which are modelled as a drive-enable flag beside the read data.

Top module: `zt_sram`

## Requirements
- R1: While reset is high and in the first cycle after it, `rvalid` and `dq_drive` are 0 and `rdata` is 0.
- R2: A read loaded at an enabled edge presents the addressed word on `rdata` with `rvalid`=1 during the cycle that follows that same edge. `dq_drive` is high only when `rvalid` is high.
- R3: Write data is taken from `wdata` at the enabled edge after the write's address edge. Only bytes whose `byte_sel` bit is 1 are changed. Bit i of `byte_sel` covers `wdata[9i+8:9i]` (default BYTE_W=9, NBYTES=4).
- R4: A read of an address whose write data is still pending returns the pending bytes merged over the stored word.
- R5: Writes and reads alternating on consecutive edges each complete with no idle cycle between them.
- R6: A load selects the block only when `ce_a_n`=0, `ce_b`=1 and `ce_c_n`=0. Any other combination is a deselect: there is no read (`rvalid`=0) and no write.
- R7: At an edge with `cke`=0, nothing changes state. Outputs hold, inputs are ignored, and pending write data is not captured.
- R8: With `burst_lin`=1 at load, beat k uses low address bits (start+k) mod 4.
- R9: With `burst_lin`=0 at load, beat k uses low address bits start XOR k.
- R10: `oe_n`=1 forces `dq_drive` to 0 combinationally, without a clock edge.
- R11: In the cycle after a selected write load (the write's data cycle), `dq_drive` and `rvalid` are 0.
- R12: An enabled edge with `sleep`=1 makes the cycle idle (`rvalid`=0). A following advance stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cke | input | 1 | Clock enable; 0 freezes the block |
| burst_adv | input | 1 | 1 = advance burst, 0 = load new access |
| we | input | 1 | 1 = write, 0 = read (at load) |
| byte_sel | input | NBYTES | Per-byte write select, active high |
| ce_a_n | input | 1 | Chip enable, active low |
| ce_b | input | 1 | Chip enable, active high |
| ce_c_n | input | 1 | Chip enable, active low |
| burst_lin | input | 1 | 1 = linear burst order, 0 = interleaved (at load) |
| sleep | input | 1 | Power-down; makes the cycle idle |
| oe_n | input | 1 | Asynchronous output enable, active low |
| addr | input | ADDR_W | Word address (at load) |
| wdata | input | NBYTES*BYTE_W | Write data, one enabled edge after address |
| rdata | output | NBYTES*BYTE_W | Read data, flow-through; 0 when no read |
| rvalid | output | 1 | Current cycle is a read |
| dq_drive | output | 1 | Data-out drivers enabled |

## Verification
The assertions assume that reset is held for at least one edge before any check counts, and that `oe_n` changes only between edges when its effect at an edge matters. They also assume that the address of a read was written before it is read. The bench respects all three. It writes every word it later reads, keeps reset high for several cycles, and changes inputs one time unit after each rising edge. It toggles `oe_n` only in mid-cycle to probe the asynchronous gate.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } zt_op_e;

    typedef struct packed {
        zt_op_e     op;
        logic       lin;
        logic [1:0] cnt;
    } zt_burst_s;

    // Low two address bits of burst beat cnt from start.
    function automatic logic [1:0] zt_beat_low(input logic [1:0] start,
                                               input logic [1:0] cnt,
                                               input logic       lin);
        return lin ? (start + cnt) : (start ^ cnt);
    endfunction

endpackage

// File: rtl/zt_burst_ctl.sv
module zt_burst_ctl
    import zt_sram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int NBYTES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cke,
    input  logic              burst_adv,
    input  logic              we,
    input  logic              sel_ok,
    input  logic              sleep,
    input  logic              burst_lin,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NBYTES-1:0] byte_sel,
    output zt_op_e            op,
    output logic [ADDR_W-1:0] eaddr,
    output logic [NBYTES-1:0] emask
);
    zt_burst_s         st;
    logic [ADDR_W-1:0] base;
    logic [NBYTES-1:0] mask;

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= '{op: OP_IDLE, lin: 1'b1, cnt: 2'd0};
            base <= '0;
            mask <= '0;
        end else if (cke) begin
            if (sleep) begin
                st.op <= OP_IDLE;
            end else if (!burst_adv) begin
                if (sel_ok) begin
                    st.op  <= we ? OP_WRITE : OP_READ;
                    st.cnt <= 2'd0;
                    st.lin <= burst_lin;
                    base   <= addr;
                    mask   <= byte_sel;
                end else begin
                    st.op <= OP_IDLE;
                end
            end else if (st.op != OP_IDLE) begin
                st.cnt <= st.cnt + 2'd1;
                mask   <= byte_sel;
            end
        end
    end

    assign op    = st.op;
    assign eaddr = {base[ADDR_W-1:2], zt_beat_low(base[1:0], st.cnt, st.lin)};
    assign emask = mask;
endmodule

// File: rtl/zt_wbuf.sv
module zt_wbuf #(
    parameter int ADDR_W = 6,
    parameter int NBYTES = 4,
    parameter int BYTE_W = 9,
    localparam int DATA_W = NBYTES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cke,
    input  logic              cap,
    input  logic [ADDR_W-1:0] cap_addr,
    input  logic [NBYTES-1:0] cap_mask,
    input  logic [DATA_W-1:0] wdata,
    output logic              commit_en,
    output logic [ADDR_W-1:0] commit_addr,
    output logic [NBYTES-1:0] commit_mask,
    output logic [DATA_W-1:0] commit_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_arr,
    output logic [DATA_W-1:0] rd_merged
);
    logic              pv;
    logic [ADDR_W-1:0] pa;
    logic [NBYTES-1:0] pm;
    logic [DATA_W-1:0] pd;
    logic              hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            pv <= 1'b0;
            pa <= '0;
            pm <= '0;
            pd <= '0;
        end else if (cke) begin
            pv <= cap;
            if (cap) begin
                pa <= cap_addr;
                pm <= cap_mask;
                pd <= wdata;
            end
        end
    end

    assign commit_en   = cke & pv;
    assign commit_addr = pa;
    assign commit_mask = pm;
    assign commit_data = pd;
    assign hit         = pv && (pa == rd_addr);

    for (genvar b = 0; b < NBYTES; b++) begin : g_fwd
        assign rd_merged[b*BYTE_W +: BYTE_W] =
            (hit && pm[b]) ? pd[b*BYTE_W +: BYTE_W] : rd_arr[b*BYTE_W +: BYTE_W];
    end
endmodule

// File: rtl/zt_array.sv
module zt_array #(
    parameter int ADDR_W = 6,
    parameter int NBYTES = 4,
    parameter int BYTE_W = 9,
    localparam int DATA_W = NBYTES * BYTE_W,
    localparam int DEPTH  = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [NBYTES-1:0] wr_mask,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    for (genvar b = 0; b < NBYTES; b++) begin : g_lane
        logic [BYTE_W-1:0] lane [DEPTH];
        always_ff @(posedge clk) begin
            if (wr_en && wr_mask[b])
                lane[wr_addr] <= wr_data[b*BYTE_W +: BYTE_W];
        end
        assign rd_data[b*BYTE_W +: BYTE_W] = lane[rd_addr];
    end
endmodule

// File: rtl/zt_sram.sv
module zt_sram
    import zt_sram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int NBYTES = 4,
    parameter int BYTE_W = 9,
    localparam int DATA_W = NBYTES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cke,
    input  logic              burst_adv,
    input  logic              we,
    input  logic [NBYTES-1:0] byte_sel,
    input  logic              ce_a_n,
    input  logic              ce_b,
    input  logic              ce_c_n,
    input  logic              burst_lin,
    input  logic              sleep,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid,
    output logic              dq_drive
);
    zt_op_e            op;
    logic [ADDR_W-1:0] eaddr;
    logic [NBYTES-1:0] emask;
    logic              sel_ok;
    logic              c_en;
    logic [ADDR_W-1:0] c_addr;
    logic [NBYTES-1:0] c_mask;
    logic [DATA_W-1:0] c_data;
    logic [DATA_W-1:0] arr_q;
    logic [DATA_W-1:0] merged;

    assign sel_ok = !ce_a_n && ce_b && !ce_c_n;

    zt_burst_ctl #(.ADDR_W(ADDR_W), .NBYTES(NBYTES)) ctl_i (
        .clk(clk), .rst(rst), .cke(cke), .burst_adv(burst_adv), .we(we),
        .sel_ok(sel_ok), .sleep(sleep), .burst_lin(burst_lin), .addr(addr),
        .byte_sel(byte_sel), .op(op), .eaddr(eaddr), .emask(emask)
    );

    zt_wbuf #(.ADDR_W(ADDR_W), .NBYTES(NBYTES), .BYTE_W(BYTE_W)) wbuf_i (
        .clk(clk), .rst(rst), .cke(cke), .cap(op == OP_WRITE),
        .cap_addr(eaddr), .cap_mask(emask), .wdata(wdata),
        .commit_en(c_en), .commit_addr(c_addr), .commit_mask(c_mask),
        .commit_data(c_data), .rd_addr(eaddr), .rd_arr(arr_q), .rd_merged(merged)
    );

    zt_array #(.ADDR_W(ADDR_W), .NBYTES(NBYTES), .BYTE_W(BYTE_W)) arr_i (
        .clk(clk), .wr_en(c_en), .wr_addr(c_addr), .wr_mask(c_mask),
        .wr_data(c_data), .rd_addr(eaddr), .rd_data(arr_q)
    );

    assign rvalid   = (op == OP_READ);
    assign rdata    = rvalid ? merged : '0;
    assign dq_drive = rvalid && !oe_n;
endmodule

// File: rtl/zt_sram_chk.sv
module zt_sram_chk #(
    parameter int DATA_W = 36
) (
    input logic              clk,
    input logic              rst,
    input logic              cke,
    input logic              burst_adv,
    input logic              we,
    input logic              ce_a_n,
    input logic              ce_b,
    input logic              ce_c_n,
    input logic              sleep,
    input logic              oe_n,
    input logic [DATA_W-1:0] rdata,
    input logic              rvalid,
    input logic              dq_drive
);
    logic sel_in;
    assign sel_in = !ce_a_n && ce_b && !ce_c_n;

    p_drive_needs_read_r2: assert property (@(posedge clk) disable iff (rst)
        dq_drive |-> rvalid);

    p_deselect_no_read_r6: assert property (@(posedge clk) disable iff (rst)
        (cke && !burst_adv && !sel_in) |=> !rvalid);

    p_stall_holds_r7: assert property (@(posedge clk) disable iff (rst)
        !cke |=> ($stable(rvalid) && $stable(rdata)));

    p_oe_gate_r10: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> !dq_drive);

    p_write_bus_off_r11: assert property (@(posedge clk) disable iff (rst)
        (cke && !burst_adv && we && sel_in && !sleep) |=> (!dq_drive && !rvalid));

    p_sleep_idle_r12: assert property (@(posedge clk) disable iff (rst)
        (cke && sleep) |=> !rvalid);
endmodule

bind zt_sram zt_sram_chk #(.DATA_W(DATA_W)) chk_i (
    .clk(clk), .rst(rst), .cke(cke), .burst_adv(burst_adv), .we(we),
    .ce_a_n(ce_a_n), .ce_b(ce_b), .ce_c_n(ce_c_n), .sleep(sleep),
    .oe_n(oe_n), .rdata(rdata), .rvalid(rvalid), .dq_drive(dq_drive)
);

// File: tb/zt_sram_tb.sv
module zt_sram_tb_top;
    localparam int CLK_P = 10;
    localparam int AW = 6;
    localparam int NB = 4;
    localparam int BW = 9;
    localparam int DW = NB * BW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cke = 1'b1;
    logic          burst_adv = 1'b0;
    logic          we = 1'b0;
    logic [NB-1:0] byte_sel = '0;
    logic          ce_a_n = 1'b1;
    logic          ce_b = 1'b0;
    logic          ce_c_n = 1'b1;
    logic          burst_lin = 1'b1;
    logic          sleep = 1'b0;
    logic          oe_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          rvalid;
    logic          dq_drive;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    logic [DW-1:0] exp_mem [1 << AW];

    always #(CLK_P / 2) clk = ~clk;

    zt_sram #(.ADDR_W(AW), .NBYTES(NB), .BYTE_W(BW)) dut_i (
        .clk(clk), .rst(rst), .cke(cke), .burst_adv(burst_adv), .we(we),
        .byte_sel(byte_sel), .ce_a_n(ce_a_n), .ce_b(ce_b), .ce_c_n(ce_c_n),
        .burst_lin(burst_lin), .sleep(sleep), .oe_n(oe_n), .addr(addr),
        .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .dq_drive(dq_drive)
    );

    function automatic logic [DW-1:0] pat(input int i);
        return (DW'(i) * 36'h1_0203_0405) ^ 36'h9_8765_4321;
    endfunction

    function automatic logic [DW-1:0] mrg(input logic [DW-1:0] o,
                                          input logic [DW-1:0] n,
                                          input logic [NB-1:0] m);
        logic [DW-1:0] r = o;
        for (int b = 0; b < NB; b++)
            if (m[b]) r[b*BW +: BW] = n[b*BW +: BW];
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, expv);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic nop_in();
        cke = 1'b1; burst_adv = 1'b0; we = 1'b0; sleep = 1'b0;
        ce_a_n = 1'b0; ce_b = 1'b0; ce_c_n = 1'b0;
    endtask

    task automatic load(input bit w, input int a, input logic [NB-1:0] m);
        cke = 1'b1; burst_adv = 1'b0; we = w; addr = AW'(a); byte_sel = m;
        ce_a_n = 1'b0; ce_b = 1'b1; ce_c_n = 1'b0; sleep = 1'b0;
    endtask

    task automatic w_single(input int a, input logic [DW-1:0] d, input logic [NB-1:0] m);
        load(1'b1, a, m);
        tick();
        chk(!dq_drive && !rvalid, "R11", DW'({dq_drive, rvalid}), '0);
        nop_in();
        wdata = d;
        tick();
        exp_mem[a] = mrg(exp_mem[a], d, m);
    endtask

    task automatic r_single(input int a, input string req);
        load(1'b0, a, '1);
        tick();
        chk(rvalid && dq_drive && rdata == exp_mem[a], req, rdata, exp_mem[a]);
        nop_in();
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) tick();
        chk(!rvalid && !dq_drive && rdata == '0, "R1 in reset", rdata, '0);
        rst = 1'b0;
        nop_in();
        tick();
        chk(!rvalid && !dq_drive && rdata == '0, "R1 after reset", rdata, '0);
    endtask

    task automatic t_fill();
        for (int i = 0; i < 64; i++) exp_mem[i] = '0;
        for (int i = 4; i < 8; i++) w_single(i, pat(i), '1);
        w_single(10, pat(10), '1);
        w_single(20, pat(20), '1);
        w_single(21, pat(21), '1);
        w_single(30, pat(30), '1);
        r_single(4, "R2 read");
        r_single(7, "R2 read");
        r_single(21, "R2 read");
    endtask

    task automatic t_fwd();
        logic [DW-1:0] d2 = 36'hA_5555_AAAA;
        logic [DW-1:0] e;
        load(1'b1, 10, 4'b0101);
        tick();
        load(1'b0, 10, '1);
        wdata = d2;
        tick();
        e = mrg(exp_mem[10], d2, 4'b0101);
        chk(rvalid && rdata == e, "R4 forward merge", rdata, e);
        exp_mem[10] = e;
        nop_in();
        tick();
        r_single(10, "R3 byte mask");
    endtask

    task automatic t_desel();
        for (int k = 0; k < 3; k++) begin
            load(1'b1, 20, '1);
            if (k == 0) ce_a_n = 1'b1;
            if (k == 1) ce_b = 1'b0;
            if (k == 2) ce_c_n = 1'b1;
            tick();
            chk(!rvalid, "R6 deselect", DW'(rvalid), '0);
            nop_in();
            wdata = '1;
            tick();
        end
        load(1'b0, 20, '1);
        ce_b = 1'b0;
        tick();
        chk(!rvalid && rdata == '0, "R6 deselected read", rdata, '0);
        r_single(20, "R6 no write");
    endtask

    task automatic t_stall();
        load(1'b0, 21, '1);
        tick();
        load(1'b0, 4, '1);
        cke = 1'b0;
        tick();
        chk(rvalid && rdata == exp_mem[21], "R7 stall hold", rdata, exp_mem[21]);
        nop_in();
        tick();
        load(1'b1, 30, '1);
        tick();
        cke = 1'b0;
        wdata = '1;
        tick();
        nop_in();
        wdata = 36'h1_2345_6789;
        tick();
        exp_mem[30] = 36'h1_2345_6789;
        r_single(30, "R7 data not taken while stalled");
    endtask

    task automatic t_oe();
        load(1'b0, 5, '1);
        tick();
        oe_n = 1'b1;
        #1;
        chk(!dq_drive && rvalid, "R10 oe off", DW'(dq_drive), '0);
        oe_n = 1'b0;
        #1;
        chk(dq_drive, "R10 oe on", DW'(dq_drive), 1);
        nop_in();
    endtask

    task automatic t_b2b();
        logic [DW-1:0] d1 = 36'h3_0F0F_0F0F;
        logic [DW-1:0] d2 = 36'hC_F0F0_F0F0;
        load(1'b1, 40, '1);
        tick();
        chk(!dq_drive && !rvalid, "R11 b2b", DW'(dq_drive), '0);
        load(1'b0, 5, '1);
        wdata = d1;
        tick();
        chk(rvalid && rdata == exp_mem[5], "R5 W then R", rdata, exp_mem[5]);
        exp_mem[40] = d1;
        load(1'b1, 41, '1);
        tick();
        chk(!dq_drive, "R11 b2b", DW'(dq_drive), '0);
        load(1'b0, 40, '1);
        wdata = d2;
        tick();
        chk(rvalid && rdata == d1, "R5 R after W", rdata, d1);
        exp_mem[41] = d2;
        load(1'b0, 41, '1);
        tick();
        chk(rvalid && rdata == d2, "R5 R after R", rdata, d2);
        nop_in();
        tick();
    endtask

    task automatic t_burst(input bit lin);
        int ea;
        load(1'b0, 5, '1);
        burst_lin = lin;
        tick();
        for (int k = 0; k < 4; k++) begin
            ea = 4 + (lin ? ((1 + k) & 3) : (1 ^ k));
            chk(rvalid && rdata == exp_mem[ea], lin ? "R8 linear" : "R9 interleaved",
                rdata, exp_mem[ea]);
            burst_adv = 1'b1;
            tick();
        end
        nop_in();
        burst_lin = 1'b1;
        tick();
    endtask

    task automatic t_sleep();
        load(1'b0, 5, '1);
        sleep = 1'b1;
        tick();
        chk(!rvalid, "R12 sleep", DW'(rvalid), '0);
        sleep = 1'b0;
        burst_adv = 1'b1;
        tick();
        chk(!rvalid, "R12 advance after sleep", DW'(rvalid), '0);
        nop_in();
        tick();
    endtask

    initial begin
        t_reset();
        t_fill();
        t_fwd();
        t_desel();
        t_stall();
        t_oe();
        t_b2b();
        t_burst(1'b1);
        t_burst(1'b0);
        t_sleep();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=hung exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule